// File: doc/BRIEF.md
# Cross-Clock Mailbox Pair

This block lets two ports running on unrelated clocks pass single words to each other outside any queue. It holds two one-word mailboxes, one per direction. A sender offers a word with a valid/ready handshake in its own clock domain. Once the word is accepted, the sender's ready stays low until the receiver has taken the word and that fact has crossed back. The receiver sees a valid (new-mail) indication in its own clock domain. It takes the word by asserting ready, which clears the indication.

Each direction keeps a request toggle in the sender domain and an acknowledge toggle in the receiver domain, and each toggle crosses through a chain of synchronizer flops. The word itself stays in a sender-side register. That register is frozen from acceptance until the acknowledge returns, so the receiver can read it without synchronizing the data bits. Back-pressure rules are as follows. A sender may hold valid for as long as it likes, and a word is taken only in a cycle where valid and ready are both high. A receiver may hold off by keeping ready low for any number of cycles, and the word and its valid indication stay as they are in the meantime.

Top module: `mailbox_xclk`

## Requirements
- R1: There are two independent 32-bit mailboxes. Port A sends to port B on `a_tx_*`/`b_rx_*`, and port B sends to port A on `b_tx_*`/`a_rx_*`. Each delivers exactly the words it accepted, in order.
- R2: A word is captured on the sender's rising clock edge when that side's tx valid and tx ready are both 1. Tx ready is 0 in the following sender cycle.
- R3: A tx valid presented while tx ready is 0 is ignored. The data on it never reaches the receiver.
- R4: The receiver's rx valid rises after the second receiver rising edge that follows the accepting sender edge.
- R5: While rx valid is 1, rx data equals the accepted word and does not change.
- R6: Rx valid stays 1 until a receiver edge where rx ready is 1, and it is 0 in the next receiver cycle.
- R7: Tx ready returns to 1 after the second sender rising edge that follows the reading receiver edge.
- R8: While the active-low asynchronous reset is low, both tx ready outputs are 1 and both rx valid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_tx_valid | input | 1 | Port A offers a word to port B |
| a_tx_ready | output | 1 | A-to-B mailbox is free |
| a_tx_data | input | 32 | Word offered by port A |
| b_rx_valid | output | 1 | New mail waiting for port B |
| b_rx_ready | input | 1 | Port B takes the waiting word |
| b_rx_data | output | 32 | Word waiting for port B |
| b_tx_valid | input | 1 | Port B offers a word to port A |
| b_tx_ready | output | 1 | B-to-A mailbox is free |
| b_tx_data | input | 32 | Word offered by port B |
| a_rx_valid | output | 1 | New mail waiting for port A |
| a_rx_ready | input | 1 | Port A takes the waiting word |
| a_rx_data | output | 32 | Word waiting for port A |

## Verification
Two pairs of events can land on the same edge. First, a sender may offer its next word on the very edge where the returning acknowledge frees the mailbox, while its receiver takes mail on the very edge the flag rises. Second, one port may write its outbound mailbox and read its inbound one on the same clock. A full-rate phase provokes both by holding every valid and ready high, and a slow-reader phase stacks ignored writes behind a busy mailbox. A behavioural model counts writes and reads, delays each count through two edges of the opposite clock, and judges ready, valid and data on every edge of both clocks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DATA_W      = 32;
  localparam int MBX_SYNC_STAGES = 2;

  typedef enum int {
    CH_A2B = 0,
    CH_B2A = 1
  } mbx_dir_e;

  localparam int MBX_NUM_CH = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], d};
      end
    end
  endgenerate

  assign q = chain[TOP];
endmodule

// File: rtl/mbx_send.sv
module mbx_send #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  output logic              ready,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ack_tog_async,
  output logic              req_tog,
  output logic [DATA_W-1:0] word
);
  logic ack_seen;
  logic take;

  mbx_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_tog_async),
    .q     (ack_seen)
  );

  // Free when the last request has been acknowledged.
  assign ready = (req_tog == ack_seen);
  assign take  = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tog <= 1'b0;
      word    <= '0;
    end else if (take) begin
      req_tog <= ~req_tog;
      word    <= data_in;
    end
  end
endmodule

// File: rtl/mbx_recv.sv
module mbx_recv #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tog_async,
  input  logic [DATA_W-1:0] word_async,
  output logic              valid,
  input  logic              ready,
  output logic [DATA_W-1:0] data_out,
  output logic              ack_tog
);
  logic req_seen;

  mbx_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tog_async),
    .q     (req_seen)
  );

  assign valid = (req_seen != ack_tog);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ack_tog <= 1'b0;
    else if (valid && ready) ack_tog <= ~ack_tog;
  end

  // Sender holds the word frozen until the acknowledge returns.
  assign data_out = word_async;
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk_snd,
  input  logic              clk_rcv,
  input  logic              rst_n,
  input  logic              snd_valid,
  output logic              snd_ready,
  input  logic [DATA_W-1:0] snd_data,
  output logic              rcv_valid,
  input  logic              rcv_ready,
  output logic [DATA_W-1:0] rcv_data
);
  logic              req_tog;
  logic              ack_tog;
  logic [DATA_W-1:0] held_word;

  mbx_send #(.DATA_W(DATA_W), .STAGES(STAGES)) u_send (
    .clk           (clk_snd),
    .rst_n         (rst_n),
    .valid         (snd_valid),
    .ready         (snd_ready),
    .data_in       (snd_data),
    .ack_tog_async (ack_tog),
    .req_tog       (req_tog),
    .word          (held_word)
  );

  mbx_recv #(.DATA_W(DATA_W), .STAGES(STAGES)) u_recv (
    .clk           (clk_rcv),
    .rst_n         (rst_n),
    .req_tog_async (req_tog),
    .word_async    (held_word),
    .valid         (rcv_valid),
    .ready         (rcv_ready),
    .data_out      (rcv_data),
    .ack_tog       (ack_tog)
  );
endmodule

// File: rtl/mailbox_xclk.sv
module mailbox_xclk
  import mbx_pkg::*;
#(
  parameter int DATA_W      = MBX_DATA_W,
  parameter int SYNC_STAGES = MBX_SYNC_STAGES
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_tx_valid,
  output logic              a_tx_ready,
  input  logic [DATA_W-1:0] a_tx_data,
  output logic              b_rx_valid,
  input  logic              b_rx_ready,
  output logic [DATA_W-1:0] b_rx_data,
  input  logic              b_tx_valid,
  output logic              b_tx_ready,
  input  logic [DATA_W-1:0] b_tx_data,
  output logic              a_rx_valid,
  input  logic              a_rx_ready,
  output logic [DATA_W-1:0] a_rx_data
);
  logic              ch_clk_snd   [MBX_NUM_CH];
  logic              ch_clk_rcv   [MBX_NUM_CH];
  logic              ch_snd_valid [MBX_NUM_CH];
  logic              ch_snd_ready [MBX_NUM_CH];
  logic [DATA_W-1:0] ch_snd_data  [MBX_NUM_CH];
  logic              ch_rcv_valid [MBX_NUM_CH];
  logic              ch_rcv_ready [MBX_NUM_CH];
  logic [DATA_W-1:0] ch_rcv_data  [MBX_NUM_CH];

  // A to B direction
  assign ch_clk_snd[CH_A2B]   = clk_a;
  assign ch_clk_rcv[CH_A2B]   = clk_b;
  assign ch_snd_valid[CH_A2B] = a_tx_valid;
  assign ch_snd_data[CH_A2B]  = a_tx_data;
  assign ch_rcv_ready[CH_A2B] = b_rx_ready;
  assign a_tx_ready           = ch_snd_ready[CH_A2B];
  assign b_rx_valid           = ch_rcv_valid[CH_A2B];
  assign b_rx_data            = ch_rcv_data[CH_A2B];

  // B to A direction
  assign ch_clk_snd[CH_B2A]   = clk_b;
  assign ch_clk_rcv[CH_B2A]   = clk_a;
  assign ch_snd_valid[CH_B2A] = b_tx_valid;
  assign ch_snd_data[CH_B2A]  = b_tx_data;
  assign ch_rcv_ready[CH_B2A] = a_rx_ready;
  assign b_tx_ready           = ch_snd_ready[CH_B2A];
  assign a_rx_valid           = ch_rcv_valid[CH_B2A];
  assign a_rx_data            = ch_rcv_data[CH_B2A];

  generate
    for (genvar g = 0; g < MBX_NUM_CH; g++) begin : g_ch
      mbx_channel #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_ch (
        .clk_snd   (ch_clk_snd[g]),
        .clk_rcv   (ch_clk_rcv[g]),
        .rst_n     (rst_n),
        .snd_valid (ch_snd_valid[g]),
        .snd_ready (ch_snd_ready[g]),
        .snd_data  (ch_snd_data[g]),
        .rcv_valid (ch_rcv_valid[g]),
        .rcv_ready (ch_rcv_ready[g]),
        .rcv_data  (ch_rcv_data[g])
      );
    end
  endgenerate
endmodule

// File: rtl/mailbox_xclk_props.sv
module mailbox_xclk_props #(
  parameter int DATA_W = 32
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              a_tx_valid,
  input logic              a_tx_ready,
  input logic [DATA_W-1:0] a_tx_data,
  input logic              b_rx_valid,
  input logic              b_rx_ready,
  input logic [DATA_W-1:0] b_rx_data,
  input logic              b_tx_valid,
  input logic              b_tx_ready,
  input logic [DATA_W-1:0] b_tx_data,
  input logic              a_rx_valid,
  input logic              a_rx_ready,
  input logic [DATA_W-1:0] a_rx_data
);
  assert_busy_after_write_a_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_tx_valid && a_tx_ready |=> !a_tx_ready);
  assert_busy_after_write_b_R2: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_tx_valid && b_tx_ready |=> !b_tx_ready);

  assert_mail_held_b_R6: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_rx_valid && !b_rx_ready |=> b_rx_valid);
  assert_mail_held_a_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_rx_valid && !a_rx_ready |=> a_rx_valid);

  assert_read_clears_b_R6: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_rx_valid && b_rx_ready |=> !b_rx_valid);
  assert_read_clears_a_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_rx_valid && a_rx_ready |=> !a_rx_valid);

  assert_word_stable_b_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_rx_valid && !b_rx_ready |=> $stable(b_rx_data));
  assert_word_stable_a_R5: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_rx_valid && !a_rx_ready |=> $stable(a_rx_data));
endmodule

bind mailbox_xclk mailbox_xclk_props #(.DATA_W(DATA_W)) u_props (.*);

// File: tb/mailbox_xclk_test.sv
`timescale 1ns/100ps
module mailbox_xclk_test;
  logic        clk_a = 1'b0;
  logic        clk_b = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_tx_valid = 1'b0;
  logic [31:0] a_tx_data  = '0;
  logic        b_rx_ready = 1'b0;
  logic        b_tx_valid = 1'b0;
  logic [31:0] b_tx_data  = '0;
  logic        a_rx_ready = 1'b0;
  logic        a_tx_ready, b_rx_valid, b_tx_ready, a_rx_valid;
  logic [31:0] b_rx_data, a_rx_data;

  mailbox_xclk uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_tx_valid(a_tx_valid), .a_tx_ready(a_tx_ready), .a_tx_data(a_tx_data),
    .b_rx_valid(b_rx_valid), .b_rx_ready(b_rx_ready), .b_rx_data(b_rx_data),
    .b_tx_valid(b_tx_valid), .b_tx_ready(b_tx_ready), .b_tx_data(b_tx_data),
    .a_rx_valid(a_rx_valid), .a_rx_ready(a_rx_ready), .a_rx_data(a_rx_data)
  );

  // 250 MHz on port A; port B rising edges never meet port A rising edges.
  always #2   clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  int n_cmp = 0;
  int n_bad = 0;
  int pv = 0;
  int pr = 0;
  bit done = 1'b0;

  // Reference model: write/read counts, each seen two edges late on the far side.
  int          ab_wr, ab_rd, ab_wr_b1, ab_wr_b2, ab_rd_a1, ab_rd_a2;
  int          ba_wr, ba_rd, ba_wr_a1, ba_wr_a2, ba_rd_b1, ba_rd_b2;
  logic [31:0] ab_word, ba_word;

  always @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      ab_wr <= 0; ab_rd_a1 <= 0; ab_rd_a2 <= 0; ab_word <= '0;
      ba_rd <= 0; ba_wr_a1 <= 0; ba_wr_a2 <= 0;
    end else begin
      if (a_tx_valid && (ab_rd_a2 == ab_wr)) begin
        ab_wr   <= ab_wr + 1;
        ab_word <= a_tx_data;
      end
      ab_rd_a1 <= ab_rd;
      ab_rd_a2 <= ab_rd_a1;
      if (a_rx_ready && (ba_wr_a2 != ba_rd)) ba_rd <= ba_rd + 1;
      ba_wr_a1 <= ba_wr;
      ba_wr_a2 <= ba_wr_a1;
    end
  end

  always @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      ba_wr <= 0; ba_rd_b1 <= 0; ba_rd_b2 <= 0; ba_word <= '0;
      ab_rd <= 0; ab_wr_b1 <= 0; ab_wr_b2 <= 0;
    end else begin
      if (b_tx_valid && (ba_rd_b2 == ba_wr)) begin
        ba_wr   <= ba_wr + 1;
        ba_word <= b_tx_data;
      end
      ba_rd_b1 <= ba_rd;
      ba_rd_b2 <= ba_rd_b1;
      if (b_rx_ready && (ab_wr_b2 != ab_rd)) ab_rd <= ab_rd + 1;
      ab_wr_b1 <= ab_wr;
      ab_wr_b2 <= ab_wr_b1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Port A: compare, then drive the next inputs.
  always @(negedge clk_a) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R8", "a_tx_ready in reset", {31'b0, a_tx_ready}, 32'd1);
        chk("R8", "a_rx_valid in reset", {31'b0, a_rx_valid}, 32'd0);
      end else begin
        chk("R2 R7", "a_tx_ready", {31'b0, a_tx_ready}, {31'b0, ab_rd_a2 == ab_wr});
        chk("R4 R6", "a_rx_valid", {31'b0, a_rx_valid}, {31'b0, ba_wr_a2 != ba_rd});
        if (ba_wr_a2 != ba_rd) chk("R1 R3 R5", "a_rx_data", a_rx_data, ba_word);
      end
      a_tx_valid = ($urandom_range(0, 99) < pv);
      a_tx_data  = $urandom;
      a_rx_ready = ($urandom_range(0, 99) < pr);
    end
  end

  // Port B: compare, then drive the next inputs.
  always @(negedge clk_b) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R8", "b_tx_ready in reset", {31'b0, b_tx_ready}, 32'd1);
        chk("R8", "b_rx_valid in reset", {31'b0, b_rx_valid}, 32'd0);
      end else begin
        chk("R2 R7", "b_tx_ready", {31'b0, b_tx_ready}, {31'b0, ba_rd_b2 == ba_wr});
        chk("R4 R6", "b_rx_valid", {31'b0, b_rx_valid}, {31'b0, ab_wr_b2 != ab_rd});
        if (ab_wr_b2 != ab_rd) chk("R1 R3 R5", "b_rx_data", b_rx_data, ab_word);
      end
      b_tx_valid = ($urandom_range(0, 99) < pv);
      b_tx_data  = $urandom;
      b_rx_ready = ($urandom_range(0, 99) < pr);
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (6) @(negedge clk_a);
    #1 rst_n = 1'b1;
    pv = 30;  pr = 30;  repeat (1500) @(negedge clk_a);   // sparse traffic
    pv = 100; pr = 100; repeat (1500) @(negedge clk_a);   // full rate, edge collisions
    pv = 100; pr = 10;  repeat (1500) @(negedge clk_a);   // slow reader, ignored writes
    @(negedge clk_a);
    #1 rst_n = 1'b0;                                      // reset with mail pending
    repeat (5) @(negedge clk_a);
    #1 rst_n = 1'b1;
    pv = 50;  pr = 50;  repeat (1500) @(negedge clk_a);
    pv = 0;   pr = 100; repeat (50)   @(negedge clk_a);   // drain
    done = 1'b1;
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule